// File: doc/BRIEF.md
# Crate Sub-Trigger Word Builder

This block sits in the slave trigger module of one crate. It receives one hit line from each of sixteen front-end modules. Each module reports how many hits it saw by the length of a pulse, counted in clock cycles. Every line is stretched by a programmable expansion time, and the stretched lines are ORed into a sub-trigger flag. A rising edge on that flag opens a summing window of programmable length. While the window is open, a counter per line measures the pulse length in cycles. When the window closes, the sixteen counts are added and the total is registered into a 16-bit word with a fixed data tag, ready for the serial link toward the master.

On cycles that carry no data, the word has an idle tag and is all zero, so the receiver can tell idle from data by the tag alone. The counting path is delayed by two cycles against the flag path. This lines the window up with the first cycle of the pulse that opened it, so a pulse starting with the trigger is counted in full.

Top module: `crate_subtrig_builder`

## Requirements
- R1: After reset, subtrig_flag_o is 0, word_valid_o is 0 and word_o is 16'h0000.
- R2: A pulse of P cycles on any hit line with expand_len_i = X raises subtrig_flag_o two clock edges after the line goes high and holds it for exactly P+X cycles.
- R3: A rising edge of subtrig_flag_o opens a window of window_len_i cycles (a value of 0 acts as 1). word_valid_o rises window_len_i+2 cycles after subtrig_flag_o rises.
- R4: A rising edge of the flag while a window is open (including its last open cycle) opens no new window and produces no extra word. Hits inside the open window are still counted.
- R5: Each line contributes the number of its high cycles that fall inside the window, where window cycle 0 is the first high cycle of the triggering pulse. A line rising d cycles later with width P contributes min(P, W−d).
- R6: A per-line count saturates at 15, however long the pulse.
- R7: Bits 11:0 of a data word hold the sum of all sixteen per-line counts, clipped at 4095.
- R8: A data word carries 4'b0100 in bits 15:12, and word_valid_o is high for exactly one cycle per window.
- R9: Whenever word_valid_o is low, word_o is 16'h0000 (idle tag 4'b0000).
- R10: A window may open in the same cycle that the previous window's word is being packed. Both words then carry their own correct sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz in the system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | 16 | One pulse-width-coded hit line per front-end module |
| expand_len_i | input | 5 | Extra cycles each line is stretched for the flag |
| window_len_i | input | 8 | Summing window length in cycles |
| subtrig_flag_o | output | 1 | OR of all stretched hit lines |
| word_o | output | 16 | Tag in bits 15:12, clipped hit sum in bits 11:0 |
| word_valid_o | output | 1 | One-cycle strobe marking a data word |

## Verification
Two events can fall in the same cycle: a new flag edge that opens a window, and the packing of the previous window's sum, where the counters must be cleared at the same edge as their totals are read. The bench provokes this with a short window and a second pulse timed so that its flag edge lands exactly in the packing cycle. It expects two words with separate sums. One cycle earlier, the same pulse lands in the last open cycle and must produce only one word. Around this case, a per-line sweep of pulse widths and multi-line patterns checks the sums arithmetically against overlap with the window and saturation at 15.

// File: rtl/crate_trig_pkg.sv
`timescale 1ns/1ps
package crate_trig_pkg;
  localparam int unsigned TAG_W = 4;
  typedef logic [TAG_W-1:0] tag_t;
  localparam tag_t DATA_TAG = 4'b0100;
  localparam tag_t IDLE_TAG = 4'b0000;
endpackage

// File: rtl/hit_stretcher.sv
`timescale 1ns/1ps
module hit_stretcher #(
  parameter int unsigned EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [EXP_W-1:0] len_i,
  output logic             stretch_o
);
  logic [EXP_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (hit_i)              cnt_n = len_i;
    else if (cnt_q != '0)   cnt_n = cnt_q - EXP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign stretch_o = hit_i | (cnt_q != '0);

  assert_stretch_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stretch_o) |-> (!$past(hit_i) || ($past(len_i) == '0)));
endmodule

// File: rtl/window_gen.sv
`timescale 1ns/1ps
module window_gen #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             start_o,
  output logic             open_o,
  output logic             emit_o
);
  logic             open_q, open_n;
  logic             emit_q, emit_n;
  logic [WIN_W-1:0] cnt_q, cnt_n;
  logic             last_cyc;

  assign start_o  = trig_i & ~open_q;
  assign last_cyc = open_q & (cnt_q == WIN_W'(1));

  always_comb begin
    open_n = open_q;
    cnt_n  = cnt_q;
    emit_n = last_cyc;
    if (start_o) begin
      open_n = 1'b1;
      cnt_n  = (len_i == '0) ? WIN_W'(1) : len_i;
    end else if (open_q) begin
      if (last_cyc) open_n = 1'b0;
      else          cnt_n  = cnt_q - WIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      emit_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_n;
      emit_q <= emit_n;
      cnt_q  <= cnt_n;
    end
  end

  assign open_o = open_q;
  assign emit_o = emit_q;

  assert_win_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> open_q);
  assert_retrig_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && trig_i && !last_cyc) |=> (open_q && cnt_q == $past(cnt_q) - WIN_W'(1)));
  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    emit_q |=> !emit_q);
endmodule

// File: rtl/width_meter.sv
`timescale 1ns/1ps
module width_meter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clear_i)                                cnt_n = '0;
    else if (en_i && hit_i && cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/sum_packer.sv
`timescale 1ns/1ps
module sum_packer import crate_trig_pkg::*; #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned SUM_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   emit_i,
  input  logic [N_CH*CNT_W-1:0]  cnts_i,
  output logic [TAG_W+SUM_W-1:0] word_o,
  output logic                   valid_o
);
  localparam int unsigned RAW_W = CNT_W + $clog2(N_CH) + 1;
  localparam int unsigned ACC_W = (RAW_W > SUM_W) ? RAW_W : SUM_W + 1;
  localparam logic [SUM_W-1:0] SUM_MAX = '1;

  logic [ACC_W-1:0]       acc;
  logic [SUM_W-1:0]       sum_clip;
  logic [TAG_W+SUM_W-1:0] word_q, word_n;
  logic                   valid_q, valid_n;

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(N_CH); i++)
      acc = acc + ACC_W'(cnts_i[i*CNT_W +: CNT_W]);
    if (acc > ACC_W'(SUM_MAX)) sum_clip = SUM_MAX;
    else                       sum_clip = acc[SUM_W-1:0];
  end

  always_comb begin
    valid_n = emit_i;
    if (emit_i) word_n = {DATA_TAG, sum_clip};
    else        word_n = {IDLE_TAG, {SUM_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_n;
      valid_q <= valid_n;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  assert_data_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (word_q[TAG_W+SUM_W-1:SUM_W] == DATA_TAG));
  assert_idle_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (word_q == '0));
endmodule

// File: rtl/crate_subtrig_builder.sv
`timescale 1ns/1ps
module crate_subtrig_builder import crate_trig_pkg::*; #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned SUM_W = 12,
  parameter int unsigned EXP_W = 5,
  parameter int unsigned WIN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        hit_i,
  input  logic [EXP_W-1:0]       expand_len_i,
  input  logic [WIN_W-1:0]       window_len_i,
  output logic                   subtrig_flag_o,
  output logic [TAG_W+SUM_W-1:0] word_o,
  output logic                   word_valid_o
);
  logic [1:0]            rst_pipe;
  logic                  rst_int_n;
  logic [N_CH-1:0]       hit_q, hit_d, hit_dd;
  logic [N_CH-1:0]       hit_q_n, hit_d_n, hit_dd_n;
  logic [N_CH-1:0]       stretched;
  logic                  flag_q, flag_prev, flag_n, flag_prev_n;
  logic                  rise;
  logic                  win_start, win_open, win_emit;
  logic [N_CH*CNT_W-1:0] cnt_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    hit_q_n     = hit_i;
    hit_d_n     = hit_q;
    hit_dd_n    = hit_d;
    flag_n      = |stretched;
    flag_prev_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q     <= '0;
      hit_d     <= '0;
      hit_dd    <= '0;
      flag_q    <= 1'b0;
      flag_prev <= 1'b0;
    end else begin
      hit_q     <= hit_q_n;
      hit_d     <= hit_d_n;
      hit_dd    <= hit_dd_n;
      flag_q    <= flag_n;
      flag_prev <= flag_prev_n;
    end
  end

  assign rise = flag_q & ~flag_prev;

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
    hit_stretcher #(.EXP_W(EXP_W)) u_stretch (
      .clk(clk), .rst_n(rst_int_n), .hit_i(hit_q[g]),
      .len_i(expand_len_i), .stretch_o(stretched[g])
    );
    width_meter #(.CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_int_n), .clear_i(win_start), .en_i(win_open),
      .hit_i(hit_dd[g]), .cnt_o(cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  window_gen #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_int_n), .trig_i(rise), .len_i(window_len_i),
    .start_o(win_start), .open_o(win_open), .emit_o(win_emit)
  );

  sum_packer #(.N_CH(N_CH), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .emit_i(win_emit), .cnts_i(cnt_flat),
    .word_o(word_o), .valid_o(word_valid_o)
  );

  assign subtrig_flag_o = flag_q;

  assert_flag_follows_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|hit_q) |=> subtrig_flag_o);
  assert_window_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && !win_open) |=> win_open);
endmodule

// File: tb/test_crate_subtrig_builder.sv
`timescale 1ns/1ps
module test_crate_subtrig_builder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hit;
  logic [4:0]  xlen;
  logic [7:0]  wlen;
  logic        flag;
  logic [15:0] word;
  logic        valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc = 0, nw = 0, nrise = 0, flag_len = 0, rise_cyc = 0, idle_bad = 0;
  int wval [8];
  int wcyc [8];
  logic flag_last = 1'b0;

  always #4 clk = ~clk;

  crate_subtrig_builder i_crate_subtrig_builder (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .expand_len_i(xlen),
    .window_len_i(wlen), .subtrig_flag_o(flag), .word_o(word),
    .word_valid_o(valid)
  );

  always @(negedge clk) begin
    cyc++;
    if (valid) begin
      if (nw < 8) begin wval[nw] = int'(word); wcyc[nw] = cyc; end
      nw++;
    end else if (word != 16'h0000) idle_bad++;
    if (flag && !flag_last) begin
      if (nrise == 0) rise_cyc = cyc;
      nrise++;
    end
    if (flag) flag_len++;
    flag_last = flag;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sum(input int win, input int w[16], input int o[16], input int base);
    int weff = (win == 0) ? 1 : win;
    int s = 0;
    for (int c = 0; c < 16; c++) begin
      int lo = (o[c] > base) ? o[c] : base;
      int hi = (o[c] + w[c] < base + weff) ? o[c] + w[c] : base + weff;
      int n  = (hi > lo) ? hi - lo : 0;
      if (w[c] == 0) n = 0;
      s += (n > 15) ? 15 : n;
    end
    return (s > 4095) ? 4095 : s;
  endfunction

  task automatic run(input int win, input int xp, input int w[16], input int o[16]);
    @(negedge clk);
    wlen = 8'(win); xlen = 5'(xp);
    nw = 0; nrise = 0; flag_len = 0;
    for (int t = 0; t < 45; t++) begin
      for (int c = 0; c < 16; c++) hit[c] = (w[c] > 0) && (t >= o[c]) && (t < o[c] + w[c]);
      @(negedge clk);
    end
    hit = '0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int w[16];
    int o[16];
    int e;
    rst_n = 1'b0; hit = '0; xlen = '0; wlen = 8'd8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(flag == 1'b0, "R1 flag", int'(flag), 0);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(word == 16'h0000, "R1 word", int'(word), 0);

    // R2: flag length P+X
    foreach (w[c]) begin w[c] = 0; o[c] = 0; end
    for (int p = 1; p <= 3; p += 2) begin
      for (int k = 0; k < 4; k++) begin
        int xs = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : 13;
        w[3] = p;
        run(4, xs, w, o);
        chk(flag_len == p + xs && nrise == 1, "R2 flag width", flag_len, p + xs);
      end
    end
    w[3] = 0;

    // R5 R6 R7 R8: per-line sweep
    for (int c = 0; c < 16; c++) begin
      for (int p = 1; p <= 17; p++) begin
        foreach (w[j]) begin w[j] = 0; o[j] = 0; end
        w[c] = p;
        run(20, 2, w, o);
        e = (p > 15) ? 15 : p;
        chk(nw == 1 && wval[0] == ('h4000 | e), "R5 R6 single line sum", wval[0], 'h4000 | e);
      end
    end

    // R7: all lines, mixed widths
    foreach (w[c]) begin w[c] = (c % 8) + 1; o[c] = 0; end
    run(20, 1, w, o);
    e = exp_sum(20, w, o, 0);
    chk(nw == 1 && wval[0] == ('h4000 | e), "R7 mixed sum", wval[0], 'h4000 | e);
    // R6 R7: all saturated, 240
    foreach (w[c]) w[c] = 20;
    run(25, 0, w, o);
    chk(nw == 1 && wval[0] == ('h4000 | 240), "R6 R7 saturated sum", wval[0], 'h4000 | 240);
    // R5: window truncates pulses
    foreach (w[c]) w[c] = 9;
    run(5, 0, w, o);
    chk(nw == 1 && wval[0] == ('h4000 | 80), "R5 truncated sum", wval[0], 'h4000 | 80);
    chk(wcyc[0] - rise_cyc == 7, "R3 latency W=5", wcyc[0] - rise_cyc, 7);
    // R3: window 0 acts as 1
    foreach (w[c]) w[c] = 0;
    w[0] = 3;
    run(0, 0, w, o);
    chk(nw == 1 && wval[0] == ('h4000 | 1), "R3 zero window sum", wval[0], 'h4001);
    chk(wcyc[0] - rise_cyc == 3, "R3 latency W=0", wcyc[0] - rise_cyc, 3);
    w[0] = 1;
    run(12, 0, w, o);
    chk(wcyc[0] - rise_cyc == 14, "R3 latency W=12", wcyc[0] - rise_cyc, 14);

    // R4: late pulse inside an open window
    foreach (w[c]) begin w[c] = 0; o[c] = 0; end
    w[0] = 1; w[5] = 4; o[5] = 3;
    run(10, 0, w, o);
    chk(nw == 1 && wval[0] == ('h4000 | 5), "R4 retrigger inside window", wval[0], 'h4005);
    // R4: flag edge in the last open cycle
    w[5] = 0; w[1] = 2; o[1] = 4;
    run(4, 0, w, o);
    chk(nw == 1 && wval[0] == ('h4000 | 1), "R4 last open cycle", wval[0], 'h4001);
    chk(nw == 1, "R4 word count", nw, 1);
    // R10: flag edge in the packing cycle
    o[1] = 5;
    run(4, 0, w, o);
    chk(nw == 2, "R10 word count", nw, 2);
    e = exp_sum(4, w, o, 0);
    chk(wval[0] == ('h4000 | e), "R10 first word", wval[0], 'h4000 | e);
    e = exp_sum(4, w, o, 5);
    chk(wval[1] == ('h4000 | e), "R10 second word", wval[1], 'h4000 | e);

    chk(idle_bad == 0, "R9 idle word zero", idle_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule